// File: doc/BRIEF.md
# Graded Refresh Urgency Scheduler

This block tracks how many refreshes each DRAM rank owes and turns that debt into a refresh request with one of three urgency grades. An internal interval timer counts controller clock cycles. Each time it expires, every rank's debt grows by one. A refresh-done acknowledge from the command sequencer pays one refresh back. The debt is capped at nine intervals, which is the longest gap the memory permits between two refreshes of a rank.

The lowest grade, opportunistic, is raised only when the rank is idle, so it costs the traffic almost nothing. The middle grade, high-priority, and the top grade, panic, are raised whatever the traffic, as the deadline comes closer. The timer period is a configuration value in clock cycles. When the high-temperature flag is set, the timer uses half that value, because hot devices need refreshing twice as often. A change of the flag takes effect when the timer next reloads. Debt already owed is kept.

The request per rank works like a valid signal, and the done acknowledge is its completion. A request stays up for as long as debt remains; the sequencer is not hurried by it. The grade may rise while a request is waiting. The sequencer should serve higher grades first. The block never drops an obligation. It only stops counting once the debt reaches nine.

Top module: `rfsh_urgency_ctl`

## Requirements
- R1: With the temperature flag low, every rank's debt grows by one every `cfg_interval_i` cycles. The first increment lands on the (P+1)-th rising edge after reset release, where P is the period.
- R2: With the temperature flag high, the period is `cfg_interval_i` shifted right by one. A result of zero is treated as one.
- R3: A change of the temperature flag alters only the periods that start after the next timer expiry. Debt is not changed by the flag.
- R4: A done pulse lowers that rank's debt by one on the next edge. A done at zero debt is ignored. Done together with a timer expiry leaves the debt unchanged, unless the debt is zero, in which case it becomes one.
- R5: Debt saturates at 9. Expiries at 9 leave it at 9.
- R6: The grade is 3 (panic) when debt is 8 or more.
- R7: The grade is 2 (high-priority) when debt is 5 to 7, whether or not the rank is idle.
- R8: The grade is 1 (opportunistic) when debt is 1 to 4 and the rank is idle. Otherwise it is 0 (none).
- R9: `req_o[r]` is high exactly when the grade of rank r is not 0. The grade of rank r sits at `level_o[2r+1:2r]`.
- R10: After reset every debt is 0, every grade is 0 and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_interval_i | input | TICK_W | Refresh interval in clock cycles at normal temperature |
| hot_i | input | 1 | High-temperature flag; halves the interval |
| rank_idle_i | input | NUM_RANKS | Rank has no pending traffic, one bit per rank |
| done_i | input | NUM_RANKS | One-cycle refresh-complete acknowledge per rank |
| req_o | output | NUM_RANKS | Refresh request per rank |
| level_o | output | 2*NUM_RANKS | Urgency grade per rank: 0 none, 1 opportunistic, 2 high, 3 panic |

## Verification
On every cycle the assertions check the debt arithmetic: an expiry adds one, a done subtracts one, and a done at zero does nothing. They also check the cap of nine, that panic follows a debt of eight or more, that a busy rank with low debt raises nothing, and that the request matches the grade. The exact period length, the halving for heat, and the rule that a flag change waits for the next expiry show up only as timing. Only the bench's scenarios can show them, by sampling the grade on the edges where it has to change. The same holds for the effect of saturation, which the bench brings out by draining a saturated rank with done pulses.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  typedef enum logic [1:0] {
    LVL_NONE   = 2'd0,
    LVL_OPPORT = 2'd1,
    LVL_HIGH   = 2'd2,
    LVL_PANIC  = 2'd3
  } rfsh_level_e;
endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
  parameter int TICK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TICK_W-1:0] cfg_interval_i,
  input  logic              hot_i,
  output logic              tick_o
);
  logic [TICK_W-1:0] cnt_q;
  logic              load_q;
  logic [TICK_W-1:0] period;

  // halve the period when hot; never allow a zero period
  always_comb begin
    period = hot_i ? (cfg_interval_i >> 1) : cfg_interval_i;
    if (period == '0) period = TICK_W'(1);
  end

  assign tick_o = !load_q && (cnt_q == '0);

  // the period is sampled only at a reload, so a flag change waits for the next expiry
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      load_q <= 1'b1;
    end else if (load_q || tick_o) begin
      cnt_q  <= period - TICK_W'(1);
      load_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_q - TICK_W'(1);
    end
  end
endmodule

// File: rtl/rfsh_debt_tracker.sv
module rfsh_debt_tracker
  import rfsh_pkg::*;
#(
  parameter int DEBT_MAX = 9,
  parameter int HIPRI_TH = 5,
  parameter int PANIC_TH = 8,
  parameter int DW       = $clog2(DEBT_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          done_i,
  input  logic          idle_i,
  output logic [DW-1:0] debt_o,
  output rfsh_level_e   level_o
);
  logic [DW-1:0] debt_q, debt_d;
  logic          pay;

  assign pay = done_i && (debt_q != '0);

  always_comb begin
    unique case ({tick_i, pay})
      2'b10:   debt_d = (debt_q == DW'(DEBT_MAX)) ? debt_q : debt_q + DW'(1);
      2'b01:   debt_d = debt_q - DW'(1);
      default: debt_d = debt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) debt_q <= '0;
    else        debt_q <= debt_d;
  end

  always_comb begin
    if (debt_q >= DW'(PANIC_TH))               level_o = LVL_PANIC;
    else if (debt_q >= DW'(HIPRI_TH))          level_o = LVL_HIGH;
    else if ((debt_q != '0) && idle_i)         level_o = LVL_OPPORT;
    else                                       level_o = LVL_NONE;
  end

  assign debt_o = debt_q;
endmodule

// File: rtl/rfsh_urgency_ctl.sv
module rfsh_urgency_ctl
  import rfsh_pkg::*;
#(
  parameter int NUM_RANKS = 4,
  parameter int TICK_W    = 16,
  parameter int DEBT_MAX  = 9,
  parameter int HIPRI_TH  = 5,
  parameter int PANIC_TH  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [TICK_W-1:0]      cfg_interval_i,
  input  logic                   hot_i,
  input  logic [NUM_RANKS-1:0]   rank_idle_i,
  input  logic [NUM_RANKS-1:0]   done_i,
  output logic [NUM_RANKS-1:0]   req_o,
  output logic [2*NUM_RANKS-1:0] level_o
);
  localparam int DW = $clog2(DEBT_MAX + 1);

  logic                  tick;
  logic [NUM_RANKS*DW-1:0] debt_flat;

  rfsh_interval_timer #(.TICK_W(TICK_W)) timer_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_interval_i (cfg_interval_i),
    .hot_i          (hot_i),
    .tick_o         (tick)
  );

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    rfsh_level_e lvl;
    rfsh_debt_tracker #(
      .DEBT_MAX (DEBT_MAX),
      .HIPRI_TH (HIPRI_TH),
      .PANIC_TH (PANIC_TH),
      .DW       (DW)
    ) trk_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick),
      .done_i  (done_i[r]),
      .idle_i  (rank_idle_i[r]),
      .debt_o  (debt_flat[r*DW +: DW]),
      .level_o (lvl)
    );
    assign level_o[2*r +: 2] = lvl;
    assign req_o[r]          = (lvl != LVL_NONE);
  end
endmodule

// File: rtl/rfsh_urgency_chk.sv
module rfsh_urgency_chk #(
  parameter int NUM_RANKS = 4,
  parameter int DEBT_MAX  = 9,
  parameter int HIPRI_TH  = 5,
  parameter int PANIC_TH  = 8,
  parameter int DW        = $clog2(DEBT_MAX + 1)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   tick,
  input logic [NUM_RANKS-1:0]   rank_idle_i,
  input logic [NUM_RANKS-1:0]   done_i,
  input logic [NUM_RANKS-1:0]   req_o,
  input logic [2*NUM_RANKS-1:0] level_o,
  input logic [NUM_RANKS*DW-1:0] debt_flat
);
  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_chk
    logic [DW-1:0] debt;
    logic [1:0]    lvl;
    assign debt = debt_flat[r*DW +: DW];
    assign lvl  = level_o[2*r +: 2];

    AST_TICK_ADDS: assert property (@(posedge clk) disable iff (!rst_n)
      tick && !done_i[r] && debt < DW'(DEBT_MAX) |=> debt == $past(debt) + DW'(1)); // R1
    AST_DONE_PAYS: assert property (@(posedge clk) disable iff (!rst_n)
      done_i[r] && !tick && debt != '0 |=> debt == $past(debt) - DW'(1)); // R4
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      done_i[r] && !tick && debt == '0 |=> debt == '0); // R4
    AST_DEBT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      debt <= DW'(DEBT_MAX)); // R5
    AST_PANIC_GRADE: assert property (@(posedge clk) disable iff (!rst_n)
      debt >= DW'(PANIC_TH) |-> lvl == 2'd3); // R6
    AST_HIGH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      debt >= DW'(HIPRI_TH) && debt < DW'(PANIC_TH) |-> lvl == 2'd2); // R7
    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !rank_idle_i[r] && debt < DW'(HIPRI_TH) |-> !req_o[r]); // R8
    AST_REQ_GRADE: assert property (@(posedge clk) disable iff (!rst_n)
      req_o[r] == (lvl != 2'd0)); // R9
    AST_RESET_CLEAR: assert property (@(posedge clk)
      !rst_n |=> debt == '0); // R10
  end
endmodule

bind rfsh_urgency_ctl rfsh_urgency_chk #(
  .NUM_RANKS (NUM_RANKS),
  .DEBT_MAX  (DEBT_MAX),
  .HIPRI_TH  (HIPRI_TH),
  .PANIC_TH  (PANIC_TH),
  .DW        (DW)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick        (tick),
  .rank_idle_i (rank_idle_i),
  .done_i      (done_i),
  .req_o       (req_o),
  .level_o     (level_o),
  .debt_flat   (debt_flat)
);

// File: tb/rfsh_urgency_ctl_tb.sv
module rfsh_urgency_ctl_tb_top;
  localparam int NR = 4;
  localparam int TW = 16;
  localparam int P  = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [TW-1:0] cfg_interval_i = TW'(P);
  logic          hot_i = 1'b0;
  logic [NR-1:0] rank_idle_i = '0;
  logic [NR-1:0] done_i = '0;
  logic [NR-1:0] req_o;
  logic [2*NR-1:0] level_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  rfsh_urgency_ctl #(.NUM_RANKS(NR), .TICK_W(TW)) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_interval_i (cfg_interval_i),
    .hot_i          (hot_i),
    .rank_idle_i    (rank_idle_i),
    .done_i         (done_i),
    .req_o          (req_o),
    .level_o        (level_o)
  );

  typedef struct packed {
    logic [7:0] k;
    logic       idle;
    logic [1:0] lvl;
  } vec_t;

  // expiries elapsed, idle for all ranks, expected grade (sampled at cycle k*P+2)
  localparam vec_t VEC [10] = '{
    '{8'd0,  1'b1, 2'd0},
    '{8'd1,  1'b0, 2'd0},
    '{8'd1,  1'b1, 2'd1},
    '{8'd4,  1'b1, 2'd1},
    '{8'd4,  1'b0, 2'd0},
    '{8'd5,  1'b0, 2'd2},
    '{8'd7,  1'b1, 2'd2},
    '{8'd8,  1'b0, 2'd3},
    '{8'd9,  1'b1, 2'd3},
    '{8'd11, 1'b0, 2'd3}
  };

  task automatic check_lvl(input string tag, input int r, input logic [1:0] exp);
    logic [1:0] got;
    got = level_o[2*r +: 2];
    checks++;
    if (got !== exp || req_o[r] !== (exp != 2'd0)) begin
      fails++;
      $display("FAIL %s rank%0d cyc%0d: level=%0d req=%0b expected level=%0d req=%0b",
               tag, r, cyc, got, req_o[r], exp, exp != 2'd0);
    end
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R10: reset state
    rank_idle_i = '1;
    do_reset();
    for (int r = 0; r < NR; r++) check_lvl("R10", r, 2'd0);

    // table walk: R6 R7 R8 R9 at normal temperature
    for (int i = 0; i < 10; i++) begin
      wait_cyc(int'(VEC[i].k) * P + 2);
      rank_idle_i = {NR{VEC[i].idle}};
      #2;
      for (int r = 0; r < NR; r++) check_lvl("R8/R7/R6 table", r, VEC[i].lvl);
    end

    // R1: exact period
    rank_idle_i = '1;
    do_reset();
    wait_cyc(P);     #2; check_lvl("R1", 0, 2'd0);
    wait_cyc(P + 1); #2; check_lvl("R1", 0, 2'd1);

    // R5 / R4: saturation and draining
    do_reset();
    wait_cyc(12 * P + 2); #2; check_lvl("R5", 0, 2'd3);
    done_i = 4'b0001;
    wait_cyc(12 * P + 3); #2; check_lvl("R5", 0, 2'd3);
    wait_cyc(12 * P + 4); #2; check_lvl("R5", 0, 2'd2);
    check_lvl("R4 other rank", 1, 2'd3);
    wait_cyc(12 * P + 11);
    done_i = 4'b0000; #2;
    check_lvl("R4 drained", 0, 2'd0);
    done_i = 4'b0001;
    wait_cyc(12 * P + 12);
    done_i = 4'b0000;
    wait_cyc(12 * P + 13); #2; check_lvl("R4 done at zero", 0, 2'd0);
    wait_cyc(13 * P + 2);  #2; check_lvl("R4 next expiry", 0, 2'd1);
    rank_idle_i = 4'b1110; #2; check_lvl("R8 busy", 0, 2'd0);
    rank_idle_i = '1;

    // R2 / R3: hot period and flag change
    hot_i = 1'b1;
    do_reset();
    wait_cyc(P / 2);          #2; check_lvl("R2", 0, 2'd0);
    wait_cyc(P / 2 + 1);      #2; check_lvl("R2", 0, 2'd1);
    wait_cyc(5 * (P / 2));    #2; check_lvl("R2", 0, 2'd1);
    wait_cyc(5 * (P / 2) + 1);#2; check_lvl("R2", 0, 2'd2);
    wait_cyc(5 * (P / 2) + 2);
    hot_i = 1'b0; #2;
    check_lvl("R3 debt kept", 0, 2'd2);
    wait_cyc(6 * (P / 2) + 2 * P);     #2; check_lvl("R3", 0, 2'd2);
    wait_cyc(6 * (P / 2) + 2 * P + 1); #2; check_lvl("R3", 0, 2'd3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule